// File: doc/BRIEF.md
# PWM Generator with Dead-Band

This block is a single timer channel built around a 16-bit counter. The counter advances on ticks from a power-of-two prescaler. In its two waveform modes it produces a pulse-width modulated signal and its complement. The counter either ramps up and wraps, which gives a sawtooth, or ramps up and back down, which gives a triangle and a centred pulse. Both outputs pass through a dead-band stage that can hold back each rising edge, so the two sides of a half bridge are never on together. When the dead-band stage is bypassed, the second output is the exact complement of the first.

The same counter can serve as an input capture unit. A synchronised external pin latches the running count on a chosen edge and raises a one-cycle interrupt pulse. The counter can also run as a plain periodic timer that pulses the interrupt at every wrap. Period and compare values are copied into shadow registers only when the counter returns to zero, so a value written mid-cycle never chops a pulse.

The channel is controlled by two state machines. The counter machine has the states IDLE, UP and DOWN:
- IDLE goes to UP when the enable is set.
- UP goes to DOWN at the top of the count, in centred mode only.
- DOWN goes to UP when the count returns to zero.
- Clearing the enable returns either UP or DOWN to IDLE.

Each output leg has its own dead-band machine with the states LOW, WAIT and HIGH:
- LOW goes to WAIT when it samples a high request.
- LOW goes straight to HIGH when the delay is zero.
- WAIT goes to HIGH once the delay has run out.
- WAIT goes back to LOW if the request drops before then.
- HIGH goes to LOW when the request drops.

Top module: `pwm_db_channel`

## Requirements
- R1: While reset is asserted, or while `en` is low, `pwm_a`, `pwm_b` and `irq` are low. `cap_value` resets to 0.
- R2: The counter advances once every 2^`presc_sel` clock cycles, with `presc_sel` running from 0 to 7 (divide by 1 to 128).
- R3: With `mode` = 00 (sawtooth), the count runs 0..P and then wraps to 0, so one period lasts P+1 ticks. The raw request for `pwm_a` is high while count < C, which gives min(C, P+1) high ticks per period.
- R4: With `mode` = 01 (triangle), the count runs 0..P..1 and repeats, so one period lasts 2P ticks. The raw request is high while count < C, which gives 2C-1 high ticks per period for 1 <= C <= P, and every tick when C > P.
- R5: The raw request for `pwm_b` is the inverse of the raw request for `pwm_a`. With `db_en` = 0, `pwm_b` is high exactly when `pwm_a` is low while a waveform mode runs.
- R6: With `db_en` = 1, each output's rising edge is delayed by `db_len` ticks and its falling edge is not delayed. A request of `db_len` ticks or fewer produces no pulse. `pwm_a` and `pwm_b` are never high together.
- R7: The values on `period` and `compare` take effect only when the count returns to 0: at the wrap, at the bottom of the triangle, or on enable.
- R8: With `mode` = 10 (capture), `cap_in` passes through a two-flop synchroniser, and a selected edge copies the current count into `cap_value`. The edge is chosen by `cap_edge`: 00 none, 01 rising, 10 falling, 11 both.
- R9: `irq` is a one-cycle pulse. It fires for each capture in mode 10, and at each wrap in mode 11 (timer, count 0..P). It never fires in modes 00 or 01.
- R10: In modes 10 and 11, `pwm_a` and `pwm_b` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel run enable; low holds the counter at 0 and loads the shadows |
| mode | input | 2 | 00 sawtooth PWM, 01 triangle PWM, 10 capture, 11 timer |
| presc_sel | input | 3 | Prescaler select, tick every 2^n clocks |
| period | input | 16 | Top of count P |
| compare | input | 16 | Compare threshold C |
| db_en | input | 1 | 1 applies the dead-band delay, 0 bypasses it |
| db_len | input | 8 | Dead-band length in ticks |
| cap_edge | input | 2 | Capture edge select |
| cap_in | input | 1 | Asynchronous capture pin |
| pwm_a | output | 1 | Main PWM output |
| pwm_b | output | 1 | Complementary PWM output |
| cap_value | output | 16 | Last captured count |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench builds the channel with its default parameters: a 16-bit counter, a 3-bit prescale select and an 8-bit dead-band length. The full 16-bit width lets capture intervals be checked modulo 65536 with the period set to all ones. Prescale selects 0 to 3 keep every measured waveform window to a few hundred cycles, while still exposing the tick spacing. Small dead-band lengths of up to five ticks reach both the shortened-pulse and the fully-suppressed cases, including the case where the compare value makes one leg permanently high.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;

    typedef enum logic [1:0] {
        MODE_EDGE    = 2'b00,
        MODE_CENTER  = 2'b01,
        MODE_CAPTURE = 2'b10,
        MODE_TIMER   = 2'b11
    } chan_mode_e;

    typedef enum logic [1:0] {
        CS_IDLE = 2'b00,
        CS_UP   = 2'b01,
        CS_DOWN = 2'b10
    } cnt_state_e;

    typedef enum logic [1:0] {
        DB_LOW  = 2'b00,
        DB_WAIT = 2'b01,
        DB_HIGH = 2'b10
    } db_state_e;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] mask;

    // low sel bits all ones -> one tick per 2^sel clocks
    always_comb mask = ~({DIV_W{1'b1}} << sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   div_cnt <= '0;
        else if (!en) div_cnt <= '0;
        else          div_cnt <= div_cnt + 1'b1;
    end

    assign tick = en && ((div_cnt & mask) == mask);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_db_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             center,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] compare,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_sh,
    output logic [CNT_W-1:0] cmp_sh,
    output logic             running,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    cnt_state_e state, nxt;
    logic       at_end;
    logic       turn_top;

    assign at_end   = (cnt >= per_sh);
    assign turn_top = at_end && center && (per_sh != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            CS_IDLE: if (en) nxt = CS_UP;
            CS_UP: begin
                if (!en)                  nxt = CS_IDLE;
                else if (tick && turn_top) nxt = CS_DOWN;
            end
            CS_DOWN: begin
                if (!en)                         nxt = CS_IDLE;
                else if (tick && cnt <= CNT_ONE) nxt = CS_UP;
            end
            default: nxt = CS_IDLE;
        endcase
    end

    // count and shadow registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            per_sh <= '0;
            cmp_sh <= '0;
        end else if (state == CS_IDLE || !en) begin
            cnt    <= '0;
            per_sh <= period;
            cmp_sh <= compare;
        end else if (tick) begin
            unique case (state)
                CS_UP: begin
                    if (turn_top) begin
                        cnt <= cnt - 1'b1;
                    end else if (at_end) begin
                        cnt    <= '0;
                        per_sh <= period;
                        cmp_sh <= compare;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                CS_DOWN: begin
                    if (cnt <= CNT_ONE) begin
                        cnt    <= '0;
                        per_sh <= period;
                        cmp_sh <= compare;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign running = (state != CS_IDLE);
    assign wrap    = en && tick && (state == CS_UP) && at_end && !turn_top;
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
    import pwm_db_pkg::*;
#(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic            db_en,
    input  logic [DB_W-1:0] db_len,
    input  logic            req,
    output logic            q
);
    db_state_e       state, nxt;
    logic [DB_W-1:0] dly;
    logic [DB_W-1:0] eff;

    assign eff = db_en ? db_len : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DB_LOW;
        else        state <= nxt;
    end

    // next state, stepped on prescaled ticks only
    always_comb begin
        nxt = state;
        if (!run) begin
            nxt = DB_LOW;
        end else if (tick) begin
            unique case (state)
                DB_LOW:  if (req) nxt = (eff == '0) ? DB_HIGH : DB_WAIT;
                DB_WAIT: begin
                    if (!req)            nxt = DB_LOW;
                    else if (dly >= eff) nxt = DB_HIGH;
                end
                DB_HIGH: if (!req) nxt = DB_LOW;
                default: nxt = DB_LOW;
            endcase
        end
    end

    // delay counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly <= '0;
        end else if (tick) begin
            if (state == DB_LOW)                     dly <= DB_W'(1);
            else if (state == DB_WAIT && dly != '1)  dly <= dly + 1'b1;
        end
    end

    // output decode
    always_comb q = (state == DB_HIGH);
endmodule

// File: rtl/pwm_capture.sv
module pwm_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [1:0]       edge_sel,
    input  logic             pin,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_value,
    output logic             hit
);
    logic s1, s2, s3;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 && !s3;
    assign fall = !s2 && s3;
    assign hit  = arm && ((edge_sel[0] && rise) || (edge_sel[1] && fall));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cap_value <= '0;
        else if (hit) cap_value <= cnt;
    end
endmodule

// File: rtl/pwm_db_channel.sv
module pwm_db_channel
    import pwm_db_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3,
    parameter int DB_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] compare,
    input  logic             db_en,
    input  logic [DB_W-1:0]  db_len,
    input  logic [1:0]       cap_edge,
    input  logic             cap_in,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic [CNT_W-1:0] cap_value,
    output logic             irq
);
    localparam int LEGS = 2;

    chan_mode_e       mode_e;
    logic             tick;
    logic             center;
    logic             run_pwm;
    logic             cnt_running;
    logic             wrap;
    logic             cap_hit;
    logic             raw_a;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] per_sh;
    logic [CNT_W-1:0] cmp_sh;
    logic [LEGS-1:0]  leg_q;

    assign mode_e  = chan_mode_e'(mode);
    assign center  = (mode_e == MODE_CENTER);
    assign run_pwm = en && (mode_e == MODE_EDGE || mode_e == MODE_CENTER);

    pwm_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .sel   (presc_sel),
        .tick  (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .tick    (tick),
        .center  (center),
        .period  (period),
        .compare (compare),
        .cnt     (cnt_val),
        .per_sh  (per_sh),
        .cmp_sh  (cmp_sh),
        .running (cnt_running),
        .wrap    (wrap)
    );

    assign raw_a = (cnt_val < cmp_sh);

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        logic leg_req;
        assign leg_req = (g == 0) ? raw_a : !raw_a;
        pwm_deadband #(.DB_W(DB_W)) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_pwm),
            .tick   (tick),
            .db_en  (db_en),
            .db_len (db_len),
            .req    (leg_req),
            .q      (leg_q[g])
        );
    end

    assign pwm_a = leg_q[0];
    assign pwm_b = leg_q[1];

    pwm_capture #(.CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (en && mode_e == MODE_CAPTURE),
        .edge_sel  (cap_edge),
        .pin       (cap_in),
        .cnt       (cnt_val),
        .cap_value (cap_value),
        .hit       (cap_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= cap_hit || (en && mode_e == MODE_TIMER && wrap);
    end
endmodule

// File: rtl/pwm_db_checker.sv
module pwm_db_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [1:0]       mode,
    input logic             pwm_a,
    input logic             pwm_b,
    input logic             irq,
    input logic [CNT_W-1:0] cap_value,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per_sh,
    input logic [CNT_W-1:0] cmp_sh,
    input logic             running
);
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_a && pwm_b)); // R6

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pwm_a && !pwm_b)); // R1

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (en && running) |-> (cnt <= per_sh)); // R3

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && cnt != '0) |-> ($stable(per_sh) && $stable(cmp_sh))); // R7

    AST_PWM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && $past(mode[1])) |-> (!pwm_a && !pwm_b)); // R10

    AST_CAP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_value) |-> ($past(en) && $past(mode) == 2'b10)); // R8

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(en) && $past(mode[1]))); // R9
endmodule

bind pwm_db_channel pwm_db_checker #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .mode      (mode),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b),
    .irq       (irq),
    .cap_value (cap_value),
    .cnt       (cnt_val),
    .per_sh    (per_sh),
    .cmp_sh    (cmp_sh),
    .running   (cnt_running)
);

// File: tb/test_pwm_db_channel.sv
module test_pwm_db_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [2:0]  presc_sel = 3'd0;
    logic [15:0] period = 16'd0;
    logic [15:0] compare = 16'd0;
    logic        db_en = 1'b0;
    logic [7:0]  db_len = 8'd0;
    logic [1:0]  cap_edge = 2'b00;
    logic        cap_in = 1'b0;
    logic        pwm_a, pwm_b, irq;
    logic [15:0] cap_value;

    int n_chk = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    int cyc = 0;
    bit finished = 1'b0;

    pwm_db_channel i_pwm_db_channel (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .presc_sel(presc_sel),
        .period(period), .compare(compare), .db_en(db_en), .db_len(db_len),
        .cap_edge(cap_edge), .cap_in(cap_in), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .cap_value(cap_value), .irq(irq)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (irq) irq_cnt <= irq_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int hi_ticks(input int len, input int total, input int db);
        if (len == 0)     return 0;
        if (len == total) return total;
        if (len > db)     return len - db;
        return 0;
    endfunction

    task automatic restart(input logic [1:0] m, input int sel, input int p, input int c,
                           input bit dbe, input int db);
        @(negedge clk);
        en = 1'b0;
        mode = m; presc_sel = 3'(sel); period = 16'(p); compare = 16'(c);
        db_en = dbe; db_len = 8'(db);
        repeat (3) @(negedge clk);
        en = 1'b1;
    endtask

    task automatic run_pwm(input bit ctr, input int sel, input int p, input int c,
                           input bit dbe, input int db);
        int dv, tot, len_a, eff, ha, hb, ov;
        restart(ctr ? 2'b01 : 2'b00, sel, p, c, dbe, db);
        dv    = 1 << sel;
        tot   = ctr ? 2 * p : p + 1;
        len_a = (c == 0) ? 0 : (c > p) ? tot : (ctr ? 2 * c - 1 : c);
        eff   = dbe ? db : 0;
        repeat (4 * tot * dv + 8) @(negedge clk);
        ha = 0; hb = 0; ov = 0;
        for (int i = 0; i < 2 * tot * dv; i++) begin
            @(negedge clk);
            ha += int'(pwm_a);
            hb += int'(pwm_b);
            ov += int'(pwm_a && pwm_b);
        end
        if (ctr) chk("R4 pwm_a high cycles", ha, 2 * dv * hi_ticks(len_a, tot, eff));
        else     chk("R3 pwm_a high cycles", ha, 2 * dv * hi_ticks(len_a, tot, eff));
        chk("R5 pwm_b high cycles", hb, 2 * dv * hi_ticks(tot - len_a, tot, eff));
        chk("R6 overlap cycles", ov, 0);
    endtask

    task automatic run_timer(input int sel, input int p);
        int dv, i0, hi;
        restart(2'b11, sel, p, 0, 1'b0, 0);
        dv = 1 << sel;
        repeat (3 * (p + 1) * dv + 8) @(negedge clk);
        i0 = irq_cnt; hi = 0;
        for (int i = 0; i < 4 * (p + 1) * dv; i++) begin
            @(negedge clk);
            hi += int'(pwm_a || pwm_b);
        end
        chk("R2 R9 timer irq pulses", irq_cnt - i0, 4);
        chk("R10 outputs in timer mode", hi, 0);
    endtask

    task automatic pin(input logic v, output int t);
        @(negedge clk);
        cap_in = v;
        t = cyc;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int i0, t1, t2, tx, c1, d;
        int unsigned seed_sink;
        seed_sink = $urandom(32'd7341);

        // reset state, R1
        repeat (3) @(negedge clk);
        chk("R1 pwm_a in reset", int'(pwm_a), 0);
        chk("R1 pwm_b in reset", int'(pwm_b), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 cap_value after reset", int'(cap_value), 0);

        // directed waveforms
        run_pwm(1'b0, 0, 9, 4, 1'b0, 0);
        run_pwm(1'b0, 1, 9, 4, 1'b0, 5);      // R5 bypass ignores db_len
        run_pwm(1'b1, 0, 8, 3, 1'b1, 2);      // R4 with dead-band
        run_pwm(1'b0, 0, 9, 2, 1'b1, 3);      // R6 short pulse suppressed
        run_pwm(1'b0, 2, 7, 8, 1'b1, 2);      // R3 compare above period
        run_pwm(1'b1, 1, 6, 0, 1'b1, 1);      // R4 compare zero

        // random waveforms
        for (int k = 0; k < 10; k++) begin
            int p, c;
            p = 2 + int'($urandom % 24);
            c = int'($urandom % (p + 2));
            run_pwm(1'($urandom % 2), int'($urandom % 3), p, c,
                    1'($urandom % 2), int'($urandom % 6));
        end

        // R1 disabled outputs
        @(negedge clk); en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 pwm_a when disabled", int'(pwm_a), 0);
        chk("R1 pwm_b when disabled", int'(pwm_b), 0);

        // R7 shadow reload only at wrap
        restart(2'b00, 0, 99, 10, 1'b0, 0);
        for (int k = 0; k < 400 && !pwm_a; k++) @(negedge clk);
        repeat (20) @(negedge clk);
        compare = 16'd50;
        d = 0;
        for (int k = 0; k < 60; k++) begin @(negedge clk); d += int'(pwm_a); end
        chk("R7 no mid-period reload", d, 0);
        repeat (150) @(negedge clk);
        d = 0;
        for (int k = 0; k < 200; k++) begin @(negedge clk); d += int'(pwm_a); end
        chk("R7 new compare after wrap", d, 100);

        // timers, R2
        run_timer(0, 5);
        run_timer(3, 4);
        for (int k = 0; k < 2; k++) run_timer(int'($urandom % 4), 3 + int'($urandom % 30));

        // capture, R8 R9 R10
        cap_edge = 2'b01;
        restart(2'b10, 0, 65535, 0, 1'b0, 0);
        repeat (5) @(negedge clk);
        i0 = irq_cnt;
        pin(1'b1, t1);
        chk("R9 irq on rising capture", irq_cnt - i0, 1);
        c1 = int'(cap_value);
        pin(1'b0, tx);
        chk("R8 falling edge ignored irq", irq_cnt - i0, 1);
        chk("R8 falling edge ignored value", int'(cap_value), c1);
        for (int k = 0; k < 3; k++) begin
            d = 40 + int'($urandom % 1500);
            repeat (d) @(negedge clk);
            pin(1'b1, t2);
            chk("R8 rising interval", (int'(cap_value) - c1) & 16'hFFFF, (t2 - t1) & 16'hFFFF);
            c1 = int'(cap_value); t1 = t2;
            pin(1'b0, tx);
        end
        chk("R10 outputs in capture mode", int'(pwm_a || pwm_b), 0);

        cap_edge = 2'b10;
        i0 = irq_cnt;
        pin(1'b1, t1);
        chk("R8 rising ignored for falling select", irq_cnt - i0, 0);
        pin(1'b0, t2);
        chk("R8 falling select captures", irq_cnt - i0, 1);

        cap_edge = 2'b11;
        i0 = irq_cnt;
        pin(1'b1, t1);
        c1 = int'(cap_value);
        pin(1'b0, t2);
        chk("R8 both edges irq count", irq_cnt - i0, 2);
        chk("R8 both edges interval", (int'(cap_value) - c1) & 16'hFFFF, (t2 - t1) & 16'hFFFF);

        cap_edge = 2'b00;
        i0 = irq_cnt;
        c1 = int'(cap_value);
        pin(1'b1, t1);
        pin(1'b0, t2);
        chk("R8 no-edge select irq", irq_cnt - i0, 0);
        chk("R8 no-edge select value", int'(cap_value), c1);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule